// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat memory burst. When a new access is loaded, the incoming address is captured: its upper bits are held as the burst base and its two lowest bits become the start value of the beat sequence. On each burst-continue cycle the low bits step to the next beat. The order of the beats is set by an order-select input and is either a wrapping increment or an XOR pattern. Every continue cycle advances the sequence, whatever kind of access it belongs to.

A hold input freezes the whole block for that clock edge, so the memory controller can stall. The full current address is driven combinationally from the internal registers, and the array uses it directly. Commands are decoded outside this block and arrive as separate load and advance strobes.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active and right after it is released, `addr_o` is all zeros.
- R2: At a clock edge where `load_i` is high and `hold_i` is low, the block captures `addr_i`, and `addr_o` equals it after that edge.
- R3: With `order_i` = 0 (linear), the k-th advance after a load with start value s gives low bits `(s + k) mod 4`.
- R4: With `order_i` = 1 (interleaved), the k-th advance after a load with start value s gives low bits `s XOR (k mod 4)`.
- R5: Advances never change `addr_o` above bit 1. Those bits stay equal to the upper bits of the loaded address.
- R6: After four advances the low bits return to the start value, and the sequence then repeats.
- R7: At an edge where `hold_i` is high, `addr_o` does not change, whatever `load_i` and `adv_i` are.
- R8: When `load_i` and `adv_i` are both high at an edge, the load wins. `addr_o` becomes `addr_i` with the beat count at zero.
- R9: At an edge where neither `load_i` nor `adv_i` is high, and `order_i` does not change, `addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Freezes all state at this edge |
| load_i | input | 1 | Capture a new address and restart the beat count |
| adv_i | input | 1 | Burst-continue: step to the next beat |
| order_i | input | 1 | 0 = linear order, 1 = interleaved order (static) |
| addr_i | input | ADDR_W | Address presented with a load |
| addr_o | output | ADDR_W | Current burst address |

## Verification
On every cycle, the checker enforces:
- hold freezes the address;
- a load captures the input address, including when it competes with an advance;
- advances keep the upper bits unchanged;
- a linear advance increments the low bits by one;
- an idle edge leaves the address unchanged.

Some behaviours need the start value and the beat history, so only the bench scenarios can show them:
- the interleaved XOR pattern;
- the wrap back to the start value after four beats;
- the reset value.

The bench covers both orders, all four start values and several upper-bit patterns.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
  parameter int ADDR_W = 20,
  parameter int LOW_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    capture_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [ADDR_W-LOW_W-1:0] upper_o,
  output logic [LOW_W-1:0]        start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o <= '0;
      start_o <= '0;
    end else if (capture_i) begin
      upper_o <= addr_i[ADDR_W-1:LOW_W];
      start_o <= addr_i[LOW_W-1:0];
    end
  end
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt #(
  parameter int LOW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [LOW_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clear_i) beat_o <= '0;
    else if (step_i)  beat_o <= beat_o + 1'b1; // wraps modulo 2**LOW_W
  end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] start_i,
  input  logic [LOW_W-1:0] beat_i,
  input  order_e           order_i,
  output logic [LOW_W-1:0] low_o
);
  logic [LOW_W-1:0] lin_seq;
  logic [LOW_W-1:0] ilv_seq;

  assign lin_seq = start_i + beat_i;

  for (genvar b = 0; b < LOW_W; b++) begin : g_ilv
    assign ilv_seq[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? ilv_seq : lin_seq;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LOW_W = 2;
  localparam int UP_W  = ADDR_W - LOW_W;

  logic             capture;
  logic             step;
  logic [UP_W-1:0]  upper_q;
  logic [LOW_W-1:0] start_q;
  logic [LOW_W-1:0] beat_q;
  logic [LOW_W-1:0] low_d;
  order_e           order_sel;

  // load has priority over advance; hold blocks both
  assign capture   = load_i & ~hold_i;
  assign step      = adv_i & ~load_i & ~hold_i;
  assign order_sel = order_e'(order_i);

  bag_base_reg #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .addr_i   (addr_i),
    .upper_o  (upper_q),
    .start_o  (start_q)
  );

  bag_beat_cnt #(.LOW_W(LOW_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(capture),
    .step_i (step),
    .beat_o (beat_q)
  );

  bag_order_map #(.LOW_W(LOW_W)) u_map (
    .start_i(start_q),
    .beat_i (beat_q),
    .order_i(order_sel),
    .low_o  (low_d)
  );

  assign addr_o = {upper_q, low_d};
endmodule

// File: rtl/bag_checks.sv
module bag_checks #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic              load_i,
  input logic              adv_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  p_hold_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (order_i != $past(order_i)) || $stable(addr_o));

  // load wins over advance (R8)
  p_load_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !hold_i) |=> addr_o == $past(addr_i));

  p_upper_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !hold_i) |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  p_linear_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !hold_i && !order_i) |=>
      order_i || (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));

  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> (order_i != $past(order_i)) || $stable(addr_o));
endmodule

bind burst_addr_gen bag_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hold_i (hold_i),
  .load_i (load_i),
  .adv_i  (adv_i),
  .order_i(order_i),
  .addr_i (addr_i),
  .addr_o (addr_o)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b0;
  logic          load = 1'b0;
  logic          adv = 1'b0;
  logic          order = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_q;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .hold_i (hold),
    .load_i (load),
    .adv_i  (adv),
    .order_i(order),
    .addr_i (addr),
    .addr_o (addr_q)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_vec++;
    if (addr_q !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_q, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    load = 1'b1; adv = 1'b0; addr = a;
    step();
    load = 1'b0;
  endtask

  initial begin
    logic [AW-1:0] base;
    logic [1:0]    exp_low;
    @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    step();
    check("R1 after reset", '0);

    // sweep: both orders, every start, several upper patterns
    for (int m = 0; m < 2; m++) begin
      for (int up = 0; up < 3; up++) begin
        for (int s = 0; s < 4; s++) begin
          order = m[0];
          base = {(up == 0) ? 6'h00 : (up == 1) ? 6'h2A : 6'h3F, 2'(s)};
          do_load(base);
          check("R2 load", base);
          adv = 1'b1;
          for (int k = 1; k <= 5; k++) begin
            step();
            exp_low = m[0] ? (2'(s) ^ 2'(k % 4)) : 2'((s + k) % 4);
            if (k == 4)      check("R6 wrap", base);
            else if (m == 0) check("R3 linear", {base[AW-1:2], exp_low});
            else             check("R4 interleaved", {base[AW-1:2], exp_low});
            if (addr_q[AW-1:2] !== base[AW-1:2]) check("R5 upper", base);
          end
          adv = 1'b0;
        end
      end
    end

    // hold freezes advance and load
    order = 1'b0;
    do_load(8'hB5);
    hold = 1'b1; adv = 1'b1;
    step();
    check("R7 hold adv", 8'hB5);
    load = 1'b1; addr = 8'h42;
    step();
    check("R7 hold load", 8'hB5);
    hold = 1'b0; load = 1'b0;
    step();
    check("R7 release", 8'hB6);
    adv = 1'b0;

    // load beats advance
    order = 1'b1;
    do_load(8'h13);
    adv = 1'b1;
    step();
    check("R4 step", 8'h12);
    load = 1'b1; addr = 8'hC6;
    step();
    check("R8 load priority", 8'hC6);
    load = 1'b0;
    step();
    check("R8 beat restarted", 8'hC7);
    adv = 1'b0;

    // idle edges
    step();
    check("R9 idle", 8'hC7);
    step();
    check("R9 idle", 8'hC7);

    // reset mid-burst
    rst_n = 1'b0;
    #1;
    check("R1 async reset", '0);
    step();
    rst_n = 1'b1;
    step();
    check("R1 after re-reset", '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule